// File: doc/BRIEF.md
# Control-Register I2C Slave for an Audio Processor

This block is the serial control port of an audio and stereo-decoder processor. A host writes it over I2C: after a start condition it sends the 7-bit device address with a write flag, then a subaddress byte, then any number of data bytes, and ends with a stop condition. The subaddress byte holds a 4-bit register index and three mode flags. One flag makes the index step forward after every data byte, so a whole block of registers can be loaded in one transfer. One flag lets register 0 be rewritten without starting the offset-cancellation cycle. One flag enables the test functions held in the last register. All sixteen 8-bit registers are presented in parallel to the signal-processing logic.

Writing register 0, the source selector, normally sends a one-cycle strobe that asks the analog front end to run a new offset-cancellation pass. A read transfer returns a status byte with the live pilot-detect (stereo) and softmute-active flags. SCL and SDA are oversampled by the system clock, synchronised and filtered before any edge, start or stop is decoded. SDA is open drain: the block only ever pulls it low. The design targets bit rates up to 500 kbit/s with a fast system clock.

Top module: `ctl_i2c_slave`

## Requirements
- R1: The slave pulls SDA low for the acknowledge only when the 7 address bits match DEV_ADDR; bit 0 of the address byte selects read (1) or write (0). After a mismatch it does not drive SDA for the rest of the transfer, and no register or strobe changes.
- R2: In the subaddress byte, bit 6 is the auto-zero hold flag, bit 5 the test flag, bit 4 the increment flag and bits 3..0 the register index. Bit 7 has no effect.
- R3: With the increment flag at 1, the index steps by one after each acknowledged data byte, and index 15 wraps to 0.
- R4: With the increment flag at 0, every data byte of the transfer goes to the same register, and the last one stays.
- R5: Every data byte written to register 0 while the hold flag is 0 raises az_strobe for exactly one clock cycle. With the hold flag at 1, register 0 still loads and no strobe is sent.
- R6: Writes to registers 1 to 15 never raise az_strobe.
- R7: A read returns a byte with bit 4 = stereo_i and bit 3 = smute_i and all other bits 0. The inputs are sampled when the byte starts. Further bytes follow while the host acknowledges, and after a host not-acknowledge SDA is released.
- R8: After reset, registers 0 to 14 read 8'h00, register 15 reads 8'hFE, and az_strobe, sda_oe and test_mode are 0.
- R9: test_mode is 1 only while bit 0 of register 15 is 1 and the test flag of the most recent subaddress byte is 1.
- R10: A start in the middle of a transfer, even in the middle of a byte, drops the partial byte and restarts address decoding. After a stop, SDA is released.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_CYC clock cycles is ignored. It adds no bit and produces no start or stop.
- R12: Register contents change only in the cycle in which the slave begins to acknowledge a complete data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| stereo_i | input | 1 | Live pilot-detect flag for the status byte |
| smute_i | input | 1 | Live softmute-active flag for the status byte |
| regs_o | output | 8*REG_CNT | Register file, register k at bits 8k+7..8k |
| az_strobe | output | 1 | One-cycle offset-cancellation request |
| test_mode | output | 1 | Test functions enabled |

## Verification
The bench targets the index wrap from 15 to 0 with increment on, repeated bytes with increment off, and the hold flag on register 0. A design that got these wrong would write the wrong register or send the offset-cancellation request when it should not. It also starts a transfer again in the middle of a data byte and injects short glitches on both lines. A design that latched partial bytes or did not filter its inputs would store shifted or stray data, or see a false stop. Reads are made with different status inputs and with multiple bytes, to catch swapped bits and an SDA left held after the host's not-acknowledge. Finally, a foreign address followed by data must leave every register unchanged.

// File: rtl/ctl_i2c_slave.sv
`timescale 1ns/1ps
module ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         FILT_CYC = 4,
  parameter int         REG_CNT  = 16,
  parameter logic [7:0] TEST_RST = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic                 stereo_i,
  input  logic                 smute_i,
  output logic [8*REG_CNT-1:0] regs_o,
  output logic                 az_strobe,
  output logic                 test_mode
);
  localparam int IW = $clog2(REG_CNT);
  localparam int CW = $clog2(FILT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_READ, S_RACK} st_t;

  logic [1:0]    scl_s, sda_s;
  logic          scl_f, sda_f, scl_d, sda_d;
  logic [CW-1:0] scl_c, sda_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11;
      scl_f <= 1'b1;  sda_f <= 1'b1;
      scl_d <= 1'b1;  sda_d <= 1'b1;
      scl_c <= '0;    sda_c <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_d <= scl_f;
      sda_d <= sda_f;
      if (scl_s[1] != scl_f) begin
        if (scl_c == CW'(FILT_CYC - 1)) begin
          scl_f <= scl_s[1];
          scl_c <= '0;
        end else scl_c <= scl_c + 1'b1;
      end else scl_c <= '0;
      if (sda_s[1] != sda_f) begin
        if (sda_c == CW'(FILT_CYC - 1)) begin
          sda_f <= sda_s[1];
          sda_c <= '0;
        end else sda_c <= sda_c + 1'b1;
      end else sda_c <= '0;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, txb;
  logic          ack_ph, sda_low;
  logic          sub_az, sub_test, sub_inc;
  logic [IW-1:0] idx;
  logic [7:0]    rf [REG_CNT];

  wire       rx_st  = (st == S_ADDR) || (st == S_SUB) || (st == S_DATA);
  wire [7:0] status = {3'b000, stereo_i, smute_i, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; txb <= '0;
      ack_ph <= 1'b0; sda_low <= 1'b0; az_strobe <= 1'b0;
      sub_az <= 1'b0; sub_test <= 1'b0; sub_inc <= 1'b0; idx <= '0;
      for (int i = 0; i < REG_CNT; i++)
        rf[i] <= (i == REG_CNT - 1) ? TEST_RST : 8'h00;
    end else begin
      az_strobe <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; ack_ph <= 1'b0; sda_low <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; ack_ph <= 1'b0; sda_low <= 1'b0;
      end else if (scl_rise) begin
        if (rx_st && !ack_ph && cnt != 4'd8) begin
          sh  <= {sh[6:0], sda_f};
          cnt <= cnt + 1'b1;
        end else if (st == S_RACK) begin
          if (sda_f) st <= S_IDLE;
          else begin
            st <= S_READ; txb <= status; cnt <= '0;
          end
        end
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0;
          if (st == S_READ) begin
            sda_low <= ~txb[7]; txb <= {txb[6:0], 1'b0}; cnt <= 4'd1;
          end else begin
            sda_low <= 1'b0; cnt <= '0;
          end
        end else if (st == S_READ) begin
          if (cnt == 4'd8) begin
            sda_low <= 1'b0; st <= S_RACK;
          end else begin
            sda_low <= ~txb[7]; txb <= {txb[6:0], 1'b0}; cnt <= cnt + 1'b1;
          end
        end else if (rx_st && cnt == 4'd8) begin
          case (st)
            S_ADDR:
              if (sh[7:1] == DEV_ADDR) begin
                ack_ph <= 1'b1; sda_low <= 1'b1;
                if (sh[0]) begin
                  st <= S_READ; txb <= status;
                end else st <= S_SUB;
              end else st <= S_IDLE;
            S_SUB: begin
              sub_az   <= sh[6];
              sub_test <= sh[5];
              sub_inc  <= sh[4];
              idx      <= sh[IW-1:0];
              ack_ph <= 1'b1; sda_low <= 1'b1; st <= S_DATA;
            end
            S_DATA: begin
              rf[idx] <= sh;
              if (idx == '0 && !sub_az) az_strobe <= 1'b1;
              if (sub_inc) idx <= idx + 1'b1;
              ack_ph <= 1'b1; sda_low <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe    = sda_low;
  assign test_mode = sub_test & rf[REG_CNT-1][0];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_out
    assign regs_o[8*g +: 8] = rf[g];
  end
endmodule

module ctl_i2c_slave_chk #(
  parameter int         REG_CNT  = 16,
  parameter logic [7:0] TEST_RST = 8'hFE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_i,
  input logic                 sda_oe,
  input logic                 az_strobe,
  input logic [8*REG_CNT-1:0] regs_o
);
  a_r5_az_single: assert property (@(posedge clk) disable iff (!rst_n)
    az_strobe |=> !az_strobe);
  a_r5_az_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    az_strobe |-> sda_oe);
  a_r12_write_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> sda_oe);
  a_r1_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  a_r8_reset_test_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> regs_o[8*REG_CNT-1 -: 8] == TEST_RST);
endmodule

bind ctl_i2c_slave ctl_i2c_slave_chk #(.REG_CNT(REG_CNT), .TEST_RST(TEST_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .az_strobe(az_strobe), .regs_o(regs_o)
);

// File: tb/ctl_i2c_slave_tb.sv
`timescale 1ns/1ps
module ctl_i2c_slave_tb;
  localparam logic [6:0] DEV = 7'h44;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic stereo = 1'b0, smute = 1'b0;
  logic sda, sda_oe, az_strobe, test_mode;
  logic [127:0] regs_o;
  int n_chk = 0, n_fail = 0, az_n = 0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;
  assign sda = sda_m & ~sda_oe;

  ctl_i2c_slave #(.DEV_ADDR(DEV), .FILT_CYC(4), .REG_CNT(16), .TEST_RST(8'hFE)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .stereo_i(stereo), .smute_i(smute), .regs_o(regs_o),
    .az_strobe(az_strobe), .test_mode(test_mode));

  always @(posedge clk) if (az_strobe) az_n <= az_n + 1;

  // {sub, glitch, nbytes, d0, d1, d2}
  localparam logic [35:0] VEC [8] = '{
    {8'h10, 2'd0, 2'd3, 8'h11, 8'h22, 8'h33},
    {8'h50, 2'd0, 2'd2, 8'hA1, 8'hB2, 8'h00},
    {8'h04, 2'd1, 2'd3, 8'h44, 8'h45, 8'h46},
    {8'h1E, 2'd0, 2'd3, 8'hE0, 8'hF0, 8'h0C},
    {8'h00, 2'd0, 2'd2, 8'h5A, 8'hA5, 8'h00},
    {8'h49, 2'd0, 2'd1, 8'h99, 8'h00, 8'h00},
    {8'h17, 2'd2, 2'd3, 8'h70, 8'h80, 8'h90},
    {8'h83, 2'd0, 2'd1, 8'h3C, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mdl_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[8*i +: 8] = mdl[i];
    return f;
  endfunction

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic put_bit(input logic b, input int g);
    hq(); sda_m = b; hq(); scl = 1'b1; hq();
    if (g == 1) begin scl = 1'b0; repeat (2) @(negedge clk); scl = 1'b1; end
    if (g == 2) begin sda_m = ~b; repeat (2) @(negedge clk); sda_m = b; end
    hq(); scl = 1'b0;
  endtask

  task automatic i2c_start();
    hq(); sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    hq(); sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq();
    repeat (20) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int g, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], (i == 3) ? g : 0);
    hq(); sda_m = 1'b1; hq(); scl = 1'b1; hq(); ack = sda; hq(); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); hq(); scl = 1'b1; hq(); d[i] = sda; hq(); scl = 1'b0;
    end
    hq(); sda_m = mack ? 1'b0 : 1'b1; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0;
  endtask

  task automatic wr_txn(input logic [7:0] sub, input int n, input logic [23:0] dat,
                        input int g, output logic ack0);
    logic a;
    i2c_start();
    send_byte({DEV, 1'b0}, 0, ack0);
    send_byte(sub, 0, a);
    for (int k = 0; k < n; k++) send_byte(dat[23-8*k -: 8], g, a);
    i2c_stop();
  endtask

  task automatic rd_txn(input int n, output logic [15:0] got, output logic rel);
    logic a;
    logic [7:0] d;
    got = '0;
    i2c_start();
    send_byte({DEV, 1'b1}, 0, a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      got = {got[7:0], d};
    end
    rel = sda_oe;
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack, rel;
    logic [15:0] got;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mdl[15] = 8'hFE;
    repeat (10) @(negedge clk);
    // R8 reset state
    chk("R8 regs after reset", regs_o, mdl_flat());
    chk("R8 outputs after reset", {125'b0, sda_oe, az_strobe, test_mode}, 128'b0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // table: R2 R3 R4 R5 R6 R11 R12
    for (int v = 0; v < 8; v++) begin
      logic [7:0] sub;
      int n, g, exp_az, ix;
      sub = VEC[v][35:28]; g = int'(VEC[v][27:26]); n = int'(VEC[v][25:24]);
      exp_az = az_n; ix = int'(sub[3:0]);
      for (int k = 0; k < n; k++) begin
        mdl[ix] = VEC[v][23-8*k -: 8];
        if (ix == 0 && !sub[6]) exp_az++;
        if (sub[4]) ix = (ix + 1) % 16;
      end
      wr_txn(sub, n, VEC[v][23:0], g, ack);
      chk($sformatf("R2 R3 R4 R11 R12 regs vec %0d", v), regs_o, mdl_flat());
      chk($sformatf("R5 R6 strobe count vec %0d", v), 128'(az_n), 128'(exp_az));
    end

    // R1 match ACK, mismatch ignored
    wr_txn(8'h02, 1, 24'h2C0000, 0, ack);
    mdl[2] = 8'h2C;
    chk("R1 ack on match", {127'b0, ack}, 128'b0);
    begin
      int az0;
      az0 = az_n;
      i2c_start();
      send_byte({DEV ^ 7'h01, 1'b0}, 0, ack);
      send_byte(8'h00, 0, rel);
      send_byte(8'hEE, 0, rel);
      i2c_stop();
      chk("R1 no ack on mismatch", {127'b0, ack}, {127'b0, 1'b1});
      chk("R1 mismatch leaves regs", regs_o, mdl_flat());
      chk("R1 mismatch no strobe", 128'(az_n), 128'(az0));
    end

    // R7 reads
    stereo = 1'b1; smute = 1'b0;
    rd_txn(1, got, rel);
    chk("R7 stereo bit", 128'(got[7:0]), 128'h10);
    stereo = 1'b0; smute = 1'b1;
    rd_txn(1, got, rel);
    chk("R7 softmute bit", 128'(got[7:0]), 128'h08);
    stereo = 1'b1;
    rd_txn(2, got, rel);
    chk("R7 two bytes", 128'(got), 128'h1818);
    chk("R7 released after nack", {127'b0, rel}, 128'b0);
    chk("R10 released after stop", {127'b0, sda_oe}, 128'b0);

    // R10 repeated start after subaddress
    i2c_start();
    send_byte({DEV, 1'b0}, 0, ack);
    send_byte(8'h05, 0, ack);
    i2c_start();
    send_byte({DEV, 1'b0}, 0, ack);
    send_byte(8'h06, 0, ack);
    send_byte(8'h77, 0, ack);
    i2c_stop();
    mdl[6] = 8'h77;
    chk("R10 restart after subaddress", regs_o, mdl_flat());
    // R10 R12 restart mid data byte
    i2c_start();
    send_byte({DEV, 1'b0}, 0, ack);
    send_byte(8'h05, 0, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 0);
    i2c_start();
    send_byte({DEV, 1'b0}, 0, ack);
    send_byte(8'h07, 0, ack);
    send_byte(8'h5A, 0, ack);
    i2c_stop();
    mdl[7] = 8'h5A;
    chk("R10 R12 partial byte dropped", regs_o, mdl_flat());

    // R9 test mode
    wr_txn(8'h2F, 1, 24'hFF0000, 0, ack);
    chk("R9 test flag and bit0 set", {127'b0, test_mode}, {127'b0, 1'b1});
    wr_txn(8'h0F, 1, 24'hFF0000, 0, ack);
    chk("R9 test flag clear", {127'b0, test_mode}, 128'b0);
    wr_txn(8'h23, 1, 24'h000000, 0, ack);
    chk("R9 flag from other register", {127'b0, test_mode}, {127'b0, 1'b1});
    wr_txn(8'h2F, 1, 24'hFE0000, 0, ack);
    chk("R9 bit0 clear", {127'b0, test_mode}, 128'b0);
    mdl[15] = 8'hFE; mdl[3] = 8'h00;
    chk("R9 regs after test writes", regs_o, mdl_flat());

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule